// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Stage

This block computes the next value of a 16-bit accumulator and of its one-bit extension flag. It combines three operand sets of unequal width: the accumulator's own present value, a 16-bit data operand, and an 8-bit character operand. A 3-bit operation code selects the result. The result is written into the accumulator on the clock edge when the load enable is high. Addition and the two rotate-through-flag shifts also write the extension flag.

The stage is meant to sit beside a shared register bus. In the same cycle, the bus can move the accumulator's present value into another register while this stage loads the accumulator with something new. Both transfers complete on the same edge. Each therefore sees the other's old value.

Two separate controls act on the extension flag alone: one clears it and one inverts it.

Top module: `acc_alu_top`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `acc_q` reads 0 and `ext_q` reads 0.
- R2: With `acc_ld` high and `op_sel` = 1 (add), the edge writes (acc + data) mod 2^16 into the accumulator and the carry out of bit 15 into the extension flag.
- R3: With `acc_ld` high and `op_sel` = 0 (AND), the edge writes the bitwise AND of the accumulator and `data_in`, and the extension flag keeps its value.
- R4: With `acc_ld` high, `op_sel` = 2 loads `data_in` unchanged. `op_sel` = 3 loads `char_in` into bits 7:0 and zeros into bits 15:8. Both leave the extension flag unchanged.
- R5: With `acc_ld` high and `op_sel` = 4, the edge writes the bitwise complement of the accumulator, and the extension flag keeps its value.
- R6: With `acc_ld` high and `op_sel` = 5 (shift right), the flag enters bit 15 and bit 0 moves into the flag. With `op_sel` = 6 (shift left), the flag enters bit 0 and bit 15 moves into the flag.
- R7: When `acc_ld` is low, or `op_sel` = 7, neither the accumulator nor the extension flag is changed by the operation path, whatever the operands are.
- R8: When no flag-writing operation is loaded, `ext_clr` clears the flag and `ext_inv` inverts it. If both are high, the clear wins.
- R9: When an add or a shift is loaded, its flag result is written, and `ext_clr` and `ext_inv` are ignored for that edge.
- R10: A loaded result appears on `acc_q` after exactly one rising edge. Until that edge, `acc_q` still shows the old value, so a concurrent bus read of the accumulator in the same cycle gets the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_ld | input | 1 | Load enable for the accumulator result |
| op_sel | input | 3 | Operation code, 0 to 7 |
| data_in | input | 16 | Data operand |
| char_in | input | 8 | Character operand |
| ext_clr | input | 1 | Clear the extension flag |
| ext_inv | input | 1 | Invert the extension flag |
| acc_q | output | 16 | Accumulator value |
| ext_q | output | 1 | Extension flag value |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a flag-writing operation (add or shift) and a direct flag control. The bench provokes it by asserting `ext_clr` or `ext_inv` on the same edge as an add with carry or a shift. It expects the arithmetic flag result to win.

The second pair is a bus read of the accumulator and a load of a new accumulator value. The bench plays the bus side: it samples `acc_q` just before the edge that loads the data operand. It expects the old value there and the new value right after the edge, as a register swap would need.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'd0,
    OP_ADD  = 3'd1,
    OP_PASS = 3'd2,
    OP_CHAR = 3'd3,
    OP_INV  = 3'd4,
    OP_SHR  = 3'd5,
    OP_SHL  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic           ext,
  input  logic [W-1:0]   data,
  input  logic [CW-1:0]  chr,
  output logic [W-1:0]   res,
  output logic           res_ext,
  output logic           op_valid,
  output logic           op_sets_ext
);
  localparam int SW = W + 1;

  logic [W-1:0] chr_ext;

  function automatic logic [SW-1:0] f_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [SW-1:0] f_shr(input logic f, input logic [W-1:0] a);
    return {f, a};
  endfunction

  function automatic logic [SW-1:0] f_shl(input logic f, input logic [W-1:0] a);
    return {a, f};
  endfunction

  generate
    if (W > CW) begin : g_pad
      assign chr_ext = {{(W-CW){1'b0}}, chr};
    end else begin : g_trunc
      assign chr_ext = chr[W-1:0];
    end
  endgenerate

  logic [SW-1:0] sum_w;
  logic [SW-1:0] shr_w;
  logic [SW-1:0] shl_w;

  assign sum_w = f_add(acc, data);
  assign shr_w = f_shr(ext, acc);
  assign shl_w = f_shl(ext, acc);

  always_comb begin
    res         = acc;
    res_ext     = ext;
    op_valid    = 1'b1;
    op_sets_ext = 1'b0;
    unique case (op)
      OP_AND:  res = acc & data;
      OP_ADD:  begin
        res         = sum_w[W-1:0];
        res_ext     = sum_w[W];
        op_sets_ext = 1'b1;
      end
      OP_PASS: res = data;
      OP_CHAR: res = chr_ext;
      OP_INV:  res = ~acc;
      OP_SHR:  begin
        res         = shr_w[W:1];
        res_ext     = shr_w[0];
        op_sets_ext = 1'b1;
      end
      OP_SHL:  begin
        res         = shl_w[W-1:0];
        res_ext     = shl_w[W];
        op_sets_ext = 1'b1;
      end
      default: op_valid = 1'b0;
    endcase
  end

  always_comb begin
    if (op_sets_ext && op == OP_SHR) begin
      AST_SHR_FLAG_IN: assert (res[W-1] == ext); // R6
    end
    if (op_sets_ext && op == OP_SHL) begin
      AST_SHL_FLAG_IN: assert (res[0] == ext); // R6
    end
  end
endmodule

// File: rtl/acc_ext_flag.sv
module acc_ext_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic alu_wr,
  input  logic alu_val,
  input  logic clr,
  input  logic inv,
  output logic ext_q
);
  logic ext_d;

  always_comb begin
    if (alu_wr)      ext_d = alu_val;
    else if (clr)    ext_d = 1'b0;
    else if (inv)    ext_d = ~ext_q;
    else             ext_d = ext_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_d;
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_wr && clr) |=> !ext_q); // R8
  AST_FLAG_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_wr && !clr && inv) |=> (ext_q != $past(ext_q))); // R8
  AST_FLAG_ALU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    alu_wr |=> (ext_q == $past(alu_val))); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_wr && !clr && !inv) |=> $stable(ext_q)); // R7
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q)); // R7
  AST_ACC_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d))); // R10
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_ld,
  input  logic [2:0]    op_sel,
  input  logic [W-1:0]  data_in,
  input  logic [CW-1:0] char_in,
  input  logic          ext_clr,
  input  logic          ext_inv,
  output logic [W-1:0]  acc_q,
  output logic          ext_q
);
  alu_op_e      op;
  logic [W-1:0] res;
  logic         res_ext;
  logic         op_valid;
  logic         op_sets_ext;
  logic         acc_load_en;
  logic         ext_alu_wr;

  assign op          = alu_op_e'(op_sel);
  assign acc_load_en = acc_ld && op_valid;
  assign ext_alu_wr  = acc_load_en && op_sets_ext;

  acc_alu_logic #(.W(W), .CW(CW)) u_logic (
    .op          (op),
    .acc         (acc_q),
    .ext         (ext_q),
    .data        (data_in),
    .chr         (char_in),
    .res         (res),
    .res_ext     (res_ext),
    .op_valid    (op_valid),
    .op_sets_ext (op_sets_ext)
  );

  acc_reg #(.W(W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (acc_load_en),
    .d     (res),
    .q     (acc_q)
  );

  acc_ext_flag u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .alu_wr  (ext_alu_wr),
    .alu_val (res_ext),
    .clr     (ext_clr),
    .inv     (ext_inv),
    .ext_q   (ext_q)
  );

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && op_sel == 3'd1) |=>
      ({ext_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(data_in)}))); // R2
  AST_CHAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && op_sel == 3'd3) |=> ((acc_q >> CW) == '0)); // R4
  AST_INVERT_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && op_sel == 3'd4) |=> (acc_q == ~$past(acc_q))); // R5
  AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd7 && !ext_clr && !ext_inv) |=> ($stable(acc_q) && $stable(ext_q))); // R7
endmodule

// File: tb/acc_alu_top_tb.sv
module acc_alu_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_ld = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [15:0] data_in = '0;
  logic [7:0]  char_in = '0;
  logic        ext_clr = 1'b0;
  logic        ext_inv = 1'b0;
  logic [15:0] acc_q;
  logic        ext_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_acc = '0;
  logic        m_ext = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_top u_dut (
    .clk(clk), .rst_n(rst_n), .acc_ld(acc_ld), .op_sel(op_sel),
    .data_in(data_in), .char_in(char_in), .ext_clr(ext_clr), .ext_inv(ext_inv),
    .acc_q(acc_q), .ext_q(ext_q)
  );

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [2:0] op, input logic [15:0] dv,
                      input logic [7:0] cv, input logic clr, input logic inv);
    logic [16:0] s;
    logic [15:0] na;
    logic        ne;
    logic        ew;
    na = m_acc; ne = m_ext; ew = 1'b0;
    if (ld) begin
      case (op)
        3'd0: na = m_acc & dv;
        3'd1: begin s = {1'b0, m_acc} + {1'b0, dv}; na = s[15:0]; ne = s[16]; ew = 1'b1; end
        3'd2: na = dv;
        3'd3: na = {8'h00, cv};
        3'd4: na = ~m_acc;
        3'd5: begin na = m_acc >> 1; na[15] = m_ext; ne = m_acc[0]; ew = 1'b1; end
        3'd6: begin na = m_acc << 1; na[0] = m_ext; ne = m_acc[15]; ew = 1'b1; end
        default: ;
      endcase
    end
    if (!ew) begin
      if (clr)      ne = 1'b0;
      else if (inv) ne = ~m_ext;
    end
    @(negedge clk);
    acc_ld = ld; op_sel = op; data_in = dv; char_in = cv; ext_clr = clr; ext_inv = inv;
    @(posedge clk);
    #1;
    m_acc = na; m_ext = ne;
    acc_ld = 1'b0; ext_clr = 1'b0; ext_inv = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", {ext_q, acc_q}, 17'h0);
  endtask

  task automatic t_add();
    step(1, 3'd2, 16'h1234, 8'h00, 0, 0);
    step(1, 3'd1, 16'h0FFF, 8'h00, 0, 0);
    chk("R2 add no carry", {ext_q, acc_q}, {m_ext, m_acc});
    chk("R2 add value", {1'b0, acc_q}, 17'h02233);
    step(1, 3'd1, 16'hF000, 8'h00, 0, 0);
    chk("R2 add with carry", {ext_q, acc_q}, 17'h11233);
  endtask

  task automatic t_and();
    step(1, 3'd0, 16'h00F0, 8'h00, 0, 0);
    chk("R3 and keeps flag", {ext_q, acc_q}, 17'h10030);
  endtask

  task automatic t_pass_char();
    step(1, 3'd2, 16'hBEEF, 8'h00, 0, 0);
    chk("R4 pass data", {ext_q, acc_q}, 17'h1BEEF);
    step(1, 3'd3, 16'hFFFF, 8'hA5, 0, 0);
    chk("R4 char zero-extend", {ext_q, acc_q}, 17'h100A5);
  endtask

  task automatic t_invert();
    step(1, 3'd4, 16'h0000, 8'h00, 0, 0);
    chk("R5 complement", {ext_q, acc_q}, 17'h1FF5A);
  endtask

  task automatic t_shift();
    step(1, 3'd2, 16'h8001, 8'h00, 1, 0);
    chk("R8 clear with pass", {ext_q, acc_q}, 17'h08001);
    step(1, 3'd5, 16'h0000, 8'h00, 0, 0);
    chk("R6 shift right", {ext_q, acc_q}, 17'h14000);
    step(1, 3'd5, 16'h0000, 8'h00, 0, 0);
    chk("R6 shift right flag in", {ext_q, acc_q}, 17'h0A000);
    step(1, 3'd6, 16'h0000, 8'h00, 0, 0);
    chk("R6 shift left", {ext_q, acc_q}, 17'h14000);
    step(1, 3'd6, 16'h0000, 8'h00, 0, 0);
    chk("R6 shift left flag in", {ext_q, acc_q}, {m_ext, m_acc});
    chk("R6 shift left value", {ext_q, acc_q}, 17'h08001);
  endtask

  task automatic t_ignore();
    step(0, 3'd1, 16'hFFFF, 8'h33, 0, 0);
    chk("R7 no load ignores add", {ext_q, acc_q}, 17'h08001);
    step(1, 3'd7, 16'h5555, 8'h77, 0, 0);
    chk("R7 code 7 ignored", {ext_q, acc_q}, 17'h08001);
    step(0, 3'd4, 16'h0000, 8'h00, 0, 0);
    chk("R7 no load ignores complement", {ext_q, acc_q}, 17'h08001);
  endtask

  task automatic t_flag_ctrl();
    step(0, 3'd0, 16'h0000, 8'h00, 0, 1);
    chk("R8 invert flag", {ext_q, acc_q}, 17'h18001);
    step(0, 3'd0, 16'h0000, 8'h00, 1, 1);
    chk("R8 clear beats invert", {ext_q, acc_q}, 17'h08001);
    step(1, 3'd4, 16'h0000, 8'h00, 0, 1);
    chk("R8 invert with complement", {ext_q, acc_q}, 17'h17FFE);
  endtask

  task automatic t_priority();
    step(1, 3'd2, 16'hFFFF, 8'h00, 1, 0);
    step(1, 3'd1, 16'h0001, 8'h00, 1, 0);
    chk("R9 add carry beats clear", {ext_q, acc_q}, 17'h10000);
    step(1, 3'd6, 16'h0000, 8'h00, 0, 1);
    chk("R9 shift beats invert", {ext_q, acc_q}, 17'h00001);
    chk("R9 model agrees", {ext_q, acc_q}, {m_ext, m_acc});
  endtask

  task automatic t_swap();
    logic [15:0] bus_seen;
    step(1, 3'd2, 16'h1234, 8'h00, 0, 0);
    @(negedge clk);
    acc_ld = 1'b1; op_sel = 3'd2; data_in = 16'hABCD;
    @(posedge clk);
    bus_seen = acc_q;
    #1;
    acc_ld = 1'b0;
    m_acc = 16'hABCD;
    chk("R10 bus sees old value", {1'b0, bus_seen}, 17'h01234);
    chk("R10 new value after edge", {1'b0, acc_q}, 17'h0ABCD);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_add();
    t_and();
    t_pass_char();
    t_invert();
    t_shift();
    t_ignore();
    t_flag_ctrl();
    t_priority();
    t_swap();
    finish_run();
  end
endmodule